// File: doc/BRIEF.md
# Serial Wire Debug Target Port

This block is the target end of a two-wire serial debug link. The host toggles a serial clock and shares one bidirectional data line with the target. The block runs directly on that serial clock and samples the line on each rising edge. It decodes eight-bit request packets. It answers each accepted request with a three-bit acknowledge after a one-cycle turnaround. It then either shifts out 32 read-data bits plus a parity bit, or takes in 32 write-data bits plus a parity bit after a second turnaround. The data line is split into an input, an output and an output enable, so the pad logic can build the tristate.

Behind the link sit two register groups:

- **Debug-port group.** This holds a fixed identification word and a control/status word. The control/status word carries system and debug power-up requests, each with an acknowledge that follows its request.
- **Memory-access group.** This holds an access-control word, a target address and a data window.

Transfers through the data window become single-cycle 32-bit reads and writes on a simple memory bus, addressed by the target address. They take effect only once the debug power-up acknowledge is set and the access-control word selects word size. The target address can step by four after each transfer.

Top module: `swd_target_port`

## Requirements
- R1: After reset the port does not drive the data line (output enable low), the power request and acknowledge bits read as zero, and neither memory strobe is asserted.
- R2: A request is sampled as start (1), group select (1 = memory-access group), read/not-write, A2, A3, parity, stop (0) and park (1), with parity equal to the XOR of the four payload bits. A request whose parity, stop or park bit is wrong gets no response: the output enable stays low and the port waits for a new start bit.
- R3: Any number of low idle cycles before a start bit leaves the port idle and does not disturb the next transaction.
- R4: One undriven turnaround cycle precedes the acknowledge. The acknowledge is three bits sent least significant first, OK = 3'b001 and FAULT = 3'b100. After the target stops driving, one more undriven turnaround cycle follows.
- R5: A read of debug-port address A[3:2]=00 returns 32'h2BA01477, least significant bit first, followed by an even-parity bit over the 32 data bits. A write to that address is acknowledged OK and changes nothing.
- R6: The control/status word sits at debug-port address A[3:2]=01. Write bit 30 is the system power-up request and write bit 28 is the debug power-up request. Read bits 31 and 29 are their acknowledges, which follow the requests one cycle later. After a write of 32'h50000000, a read returns 32'hF0000000.
- R7: While the debug power-up acknowledge is low, any memory-access-group request is answered FAULT with no data phase, and it changes no register and strobes no memory.
- R8: In the memory-access group, A[3:2]=00 is the access-control word, 01 is the target address and 11 is the data window. The access-control word and the target address read back as written.
- R9: While access-control bits [2:0] differ from 3'b010 (word size), data-window reads return 32'hFFFFFFFF and data-window writes reach no memory.
- R10: With word size selected, a data-window write stores the write data at the target address, and a data-window read returns the memory word at the target address.
- R11: When access-control bits [5:4] are 2'b01, the target address advances by 4 after each data-window transfer. Otherwise it holds.
- R12: A write whose data parity bit does not match the even parity of its 32 data bits is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial debug clock; the line is sampled on rising edges |
| rst_n | input | 1 | Active-low asynchronous reset |
| swdio_i | input | 1 | Data line as seen by the target |
| swdio_o | output | 1 | Data bit driven by the target |
| swdio_oe | output | 1 | High while the target drives the data line |
| mem_addr | output | 32 | Memory bus address (target address register) |
| mem_wdata | output | 32 | Memory bus write data |
| mem_we | output | 1 | Memory write strobe, one cycle |
| mem_re | output | 1 | Memory read strobe, one cycle; read data is taken in the same cycle |
| mem_rdata | input | 32 | Memory bus read data |

## Verification
The assertions run on every cycle and cover the following:

- The line is always released through a turnaround state, and drive only starts after the request turnaround.
- The acknowledge is a single legal code.
- A power-up acknowledge never rises without its request.
- Memory strobes only occur with debug power acknowledged.
- Auto-increment steps the address by exactly four.

Only the directed scenarios can show the rest:

- The actual bit streams: identification value and parity, acknowledge order, and control/status read-back.
- Silence after a malformed request.
- Data-window gating by the access-control size.
- Rejection of bad write parity.
- Memory contents at the right addresses.

// File: rtl/swd_pkg.sv
package swd_pkg;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_TRN1,
        ST_ACK,
        ST_RDATA,
        ST_RPAR,
        ST_TRN2,
        ST_WDATA,
        ST_WPAR
    } link_st_e;

    typedef struct packed {
        logic       ap;
        logic       rnw;
        logic [1:0] a;
    } req_t;

endpackage

// File: rtl/swd_link.sv
module swd_link
    import swd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swdio_i,
    output logic              swdio_o,
    output logic              swdio_oe,
    output req_t              req_o,
    input  logic              fault_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              rd_strobe_o,
    output logic              wr_strobe_o,
    output logic [DATA_W-1:0] wdata_o
);

    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        link_st_e          state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sr;
        req_t              req;
        logic              par;
        logic              bad;
        logic [2:0]        ack;
        logic              to_wr;
    } link_s;

    link_s q, d;

    always_comb begin
        d           = q;
        rd_strobe_o = 1'b0;
        wr_strobe_o = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (swdio_i) begin
                    d.state = ST_REQ;
                    d.cnt   = '0;
                    d.par   = 1'b0;
                    d.bad   = 1'b0;
                end
            end
            ST_REQ: begin
                d.cnt = q.cnt + 1'b1;
                case (q.cnt)
                    CNT_W'(0): begin d.req.ap   = swdio_i; d.par = q.par ^ swdio_i; end
                    CNT_W'(1): begin d.req.rnw  = swdio_i; d.par = q.par ^ swdio_i; end
                    CNT_W'(2): begin d.req.a[0] = swdio_i; d.par = q.par ^ swdio_i; end
                    CNT_W'(3): begin d.req.a[1] = swdio_i; d.par = q.par ^ swdio_i; end
                    CNT_W'(4): d.bad = q.bad | (swdio_i != q.par);
                    CNT_W'(5): d.bad = q.bad | swdio_i;
                    default: begin
                        d.state = (q.bad || !swdio_i) ? ST_IDLE : ST_TRN1;
                    end
                endcase
            end
            ST_TRN1: begin
                d.ack   = fault_i ? ACK_FAULT : ACK_OK;
                d.state = ST_ACK;
                d.cnt   = '0;
            end
            ST_ACK: begin
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(2)) begin
                    d.cnt   = '0;
                    d.par   = 1'b0;
                    d.to_wr = 1'b0;
                    if (q.ack != ACK_OK) begin
                        d.state = ST_TRN2;
                    end else if (q.req.rnw) begin
                        d.state     = ST_RDATA;
                        d.sr        = rdata_i;
                        rd_strobe_o = 1'b1;
                    end else begin
                        d.state = ST_TRN2;
                        d.to_wr = 1'b1;
                    end
                end
            end
            ST_RDATA: begin
                d.sr  = q.sr >> 1;
                d.par = q.par ^ q.sr[0];
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(DATA_W - 1)) d.state = ST_RPAR;
            end
            ST_RPAR: begin
                d.state = ST_TRN2;
                d.to_wr = 1'b0;
            end
            ST_TRN2: begin
                d.state = q.to_wr ? ST_WDATA : ST_IDLE;
                d.cnt   = '0;
                d.par   = 1'b0;
                d.to_wr = 1'b0;
            end
            ST_WDATA: begin
                d.sr  = {swdio_i, q.sr[DATA_W-1:1]};
                d.par = q.par ^ swdio_i;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == CNT_W'(DATA_W - 1)) d.state = ST_WPAR;
            end
            ST_WPAR: begin
                wr_strobe_o = (swdio_i == q.par);
                d.state     = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        swdio_oe = 1'b0;
        swdio_o  = 1'b0;
        case (q.state)
            ST_ACK:   begin swdio_oe = 1'b1; swdio_o = q.ack[q.cnt[1:0]]; end
            ST_RDATA: begin swdio_oe = 1'b1; swdio_o = q.sr[0];           end
            ST_RPAR:  begin swdio_oe = 1'b1; swdio_o = q.par;             end
            default: ;
        endcase
    end

    assign req_o   = q.req;
    assign wdata_o = q.sr;

    // R4: the line is always handed back through a turnaround cycle
    assert_release_via_trn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swdio_oe) |-> q.state == ST_TRN2);

    // R4: target drive starts only after the request turnaround
    assert_drive_after_trn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swdio_oe) |-> $past(q.state) == ST_TRN1);

    // R4: acknowledge holds exactly one legal code
    assert_ack_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.state == ST_ACK |-> $countones(q.ack) == 1);

endmodule

// File: rtl/swd_regs.sv
module swd_regs
    import swd_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] IDCODE = 32'h2BA01477
) (
    input  logic              clk,
    input  logic              rst_n,
    input  req_t              req_i,
    input  logic              rd_strobe_i,
    input  logic              wr_strobe_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              fault_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              dbg_pwr_o,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    localparam logic [1:0] A_CSW = 2'd0;
    localparam logic [1:0] A_TAR = 2'd1;
    localparam logic [1:0] A_DRW = 2'd3;
    localparam logic [1:0] A_ID  = 2'd0;
    localparam logic [1:0] A_CTL = 2'd1;

    typedef struct packed {
        logic              sys_req;
        logic              sys_ack;
        logic              dbg_req;
        logic              dbg_ack;
        logic [DATA_W-1:0] csw;
        logic [DATA_W-1:0] tar;
    } regs_s;

    regs_s q, d;
    logic  size_ok, autoinc, drw_sel;

    assign size_ok = (q.csw[2:0] == 3'b010);
    assign autoinc = (q.csw[5:4] == 2'b01);
    assign drw_sel = req_i.ap && (req_i.a == A_DRW) && size_ok;

    assign fault_o     = req_i.ap && !q.dbg_ack;
    assign dbg_pwr_o   = q.dbg_ack;
    assign mem_addr_o  = q.tar;
    assign mem_wdata_o = wdata_i;
    assign mem_re_o    = rd_strobe_i && drw_sel;
    assign mem_we_o    = wr_strobe_i && drw_sel;

    always_comb begin
        rdata_o = '0;
        if (!req_i.ap) begin
            if (req_i.a == A_ID)       rdata_o = DATA_W'(IDCODE);
            else if (req_i.a == A_CTL) rdata_o = {q.sys_ack, q.sys_req, q.dbg_ack,
                                                  q.dbg_req, (DATA_W - 4)'(0)};
        end else begin
            case (req_i.a)
                A_CSW:   rdata_o = q.csw;
                A_TAR:   rdata_o = q.tar;
                A_DRW:   rdata_o = size_ok ? mem_rdata_i : '1;
                default: rdata_o = '0;
            endcase
        end
    end

    always_comb begin
        d         = q;
        d.sys_ack = q.sys_req;
        d.dbg_ack = q.dbg_req;
        if (wr_strobe_i) begin
            if (!req_i.ap && req_i.a == A_CTL) begin
                d.sys_req = wdata_i[30];
                d.dbg_req = wdata_i[28];
            end else if (req_i.ap && req_i.a == A_CSW) begin
                d.csw = wdata_i;
            end else if (req_i.ap && req_i.a == A_TAR) begin
                d.tar = wdata_i;
            end
        end
        if ((mem_we_o || mem_re_o) && autoinc) d.tar = q.tar + DATA_W'(4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6: a power acknowledge never rises without its request
    assert_dbg_ack_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.dbg_ack) |-> $past(q.dbg_req));
    assert_sys_ack_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sys_ack) |-> $past(q.sys_req));

    // R11: auto-increment steps the address by one word
    assert_tar_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) && autoinc |=> q.tar == $past(q.tar) + DATA_W'(4));

endmodule

// File: rtl/swd_target_port.sv
module swd_target_port
    import swd_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter logic [31:0] IDCODE = 32'h2BA01477
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swdio_i,
    output logic              swdio_o,
    output logic              swdio_oe,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata
);

    req_t              req;
    logic              fault, rd_strobe, wr_strobe, dbg_pwr;
    logic [DATA_W-1:0] rdata, wdata;

    swd_link #(.DATA_W(DATA_W)) i_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .swdio_i     (swdio_i),
        .swdio_o     (swdio_o),
        .swdio_oe    (swdio_oe),
        .req_o       (req),
        .fault_i     (fault),
        .rdata_i     (rdata),
        .rd_strobe_o (rd_strobe),
        .wr_strobe_o (wr_strobe),
        .wdata_o     (wdata)
    );

    swd_regs #(.DATA_W(DATA_W), .IDCODE(IDCODE)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .rd_strobe_i (rd_strobe),
        .wr_strobe_i (wr_strobe),
        .wdata_i     (wdata),
        .fault_o     (fault),
        .rdata_o     (rdata),
        .dbg_pwr_o   (dbg_pwr),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .mem_rdata_i (mem_rdata)
    );

    // R7: the memory bus is only used with debug power acknowledged
    assert_mem_powered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> dbg_pwr);

    // R1: the two strobes never coincide
    assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

// File: tb/test_swd_target_port.sv
module test_swd_target_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swdio_i = 1'b0;
    logic        swdio_o, swdio_oe;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re;
    logic [31:0] mem [16];

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[5:2]];

    swd_target_port i_swd_target_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .swdio_i   (swdio_i),
        .swdio_o   (swdio_o),
        .swdio_oe  (swdio_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one bit slot: sample the target, then drive the host bit for the next edge
    task automatic slot(input logic dv, output logic o, output logic oe);
        @(negedge clk);
        o       = swdio_o;
        oe      = swdio_oe;
        swdio_i = dv;
    endtask

    task automatic send_req(input logic ap, input logic rnw, input logic [1:0] a,
                            input logic flip);
        logic o, oe;
        logic [7:0] b;
        b = {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1] ^ flip, a[1], a[0], rnw, ap, 1'b1};
        for (int i = 0; i < 8; i++) slot(b[i], o, oe);
    endtask

    task automatic get_ack(output logic [2:0] ack, output logic trn_quiet);
        logic o, oe;
        slot(1'b0, o, oe);
        trn_quiet = !oe;
        for (int i = 0; i < 3; i++) begin
            slot(1'b0, o, oe);
            ack[i] = oe ? o : 1'bx;
        end
    endtask

    task automatic rd(input logic ap, input logic [1:0] a, output logic [2:0] ack,
                      output logic [31:0] data, output logic par_ok);
        logic o, oe, p, q;
        send_req(ap, 1'b1, a, 1'b0);
        get_ack(ack, q);
        data = '1; par_ok = 1'b0;
        if (ack == 3'b001) begin
            for (int i = 0; i < 32; i++) begin
                slot(1'b0, o, oe);
                data[i] = o;
            end
            slot(1'b0, p, oe);
            par_ok = (p == ^data);
        end
        slot(1'b0, o, oe);
    endtask

    task automatic wr(input logic ap, input logic [1:0] a, input logic [31:0] v,
                      input logic badpar, output logic [2:0] ack);
        logic o, oe, q;
        send_req(ap, 1'b0, a, 1'b0);
        get_ack(ack, q);
        slot(1'b0, o, oe);
        if (ack == 3'b001) begin
            for (int i = 0; i < 32; i++) slot(v[i], o, oe);
            slot((^v) ^ badpar, o, oe);
            slot(1'b0, o, oe);
        end
    endtask

    task automatic t_reset;
        logic [2:0] ack; logic [31:0] v; logic pk;
        chk(swdio_oe == 1'b0, "R1 oe after reset", {31'b0, swdio_oe}, 0);
        chk(!mem_we && !mem_re, "R1 strobes after reset", {30'b0, mem_we, mem_re}, 0);
        rd(1'b0, 2'd1, ack, v, pk);
        chk(v == 32'h0, "R1 ctrl after reset", v, 32'h0);
    endtask

    task automatic t_idle_then_id;
        logic [2:0] ack; logic [31:0] v; logic pk, o, oe, quiet;
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            slot(1'b0, o, oe);
            if (oe) quiet = 1'b0;
        end
        chk(quiet, "R3 idle zeros keep line released", {31'b0, quiet}, 1);
        send_req(1'b0, 1'b1, 2'd0, 1'b0);
        get_ack(ack, quiet);
        chk(quiet, "R4 turnaround before ack undriven", {31'b0, quiet}, 1);
        chk(ack == 3'b001, "R4 ack OK lsb first", {29'b0, ack}, 32'h1);
        for (int i = 0; i < 32; i++) begin
            slot(1'b0, o, oe);
            v[i] = o;
        end
        slot(1'b0, pk, oe);
        chk(v == 32'h2BA01477, "R5 identification value", v, 32'h2BA01477);
        chk(pk == ^32'h2BA01477, "R5 read parity", {31'b0, pk}, {31'b0, ^32'h2BA01477});
        slot(1'b0, o, oe);
        chk(!oe, "R4 turnaround after read undriven", {31'b0, oe}, 0);
    endtask

    task automatic t_id_write;
        logic [2:0] ack; logic [31:0] v; logic pk;
        wr(1'b0, 2'd0, 32'h0000_001E, 1'b0, ack);
        chk(ack == 3'b001, "R5 id write ack OK", {29'b0, ack}, 1);
        rd(1'b0, 2'd0, ack, v, pk);
        chk(v == 32'h2BA01477, "R5 id unchanged after write", v, 32'h2BA01477);
    endtask

    task automatic t_bad_request;
        logic o, oe, quiet;
        logic [2:0] ack; logic [31:0] v; logic pk;
        send_req(1'b0, 1'b1, 2'd0, 1'b1);
        quiet = 1'b1;
        for (int i = 0; i < 6; i++) begin
            slot(1'b0, o, oe);
            if (oe) quiet = 1'b0;
        end
        chk(quiet, "R2 bad request parity ignored", {31'b0, quiet}, 1);
        rd(1'b0, 2'd0, ack, v, pk);
        chk(ack == 3'b001 && v == 32'h2BA01477, "R2 recovers after bad request", v,
            32'h2BA01477);
    endtask

    task automatic t_fault_unpowered;
        logic [2:0] ack; logic [31:0] v; logic pk;
        wr(1'b1, 2'd0, 32'h0000_0002, 1'b0, ack);
        chk(ack == 3'b100, "R7 unpowered AP write FAULT", {29'b0, ack}, 32'h4);
        rd(1'b1, 2'd0, ack, v, pk);
        chk(ack == 3'b100, "R7 unpowered AP read FAULT", {29'b0, ack}, 32'h4);
    endtask

    task automatic t_power;
        logic [2:0] ack; logic [31:0] v; logic pk;
        wr(1'b0, 2'd1, 32'h5000_0000, 1'b0, ack);
        chk(ack == 3'b001, "R6 ctrl write ack", {29'b0, ack}, 1);
        rd(1'b0, 2'd1, ack, v, pk);
        chk(v == 32'hF000_0000, "R6 power request and ack", v, 32'hF000_0000);
        rd(1'b1, 2'd0, ack, v, pk);
        chk(ack == 3'b001 && v == 32'h0, "R7 csw untouched by faulted write", v, 0);
    endtask

    task automatic t_before_csw;
        logic [2:0] ack; logic [31:0] v; logic pk;
        wr(1'b1, 2'd1, 32'h0000_0008, 1'b0, ack);
        wr(1'b1, 2'd3, 32'h1234_5678, 1'b0, ack);
        chk(mem[2] == 32'hA5A5_0002, "R9 write without size blocked", mem[2], 32'hA5A50002);
        rd(1'b1, 2'd3, ack, v, pk);
        chk(v == 32'hFFFF_FFFF, "R9 read without size all ones", v, 32'hFFFFFFFF);
    endtask

    task automatic t_word_access;
        logic [2:0] ack; logic [31:0] v; logic pk;
        wr(1'b1, 2'd0, 32'h0000_0002, 1'b0, ack);
        wr(1'b1, 2'd1, 32'h0000_0008, 1'b0, ack);
        rd(1'b1, 2'd0, ack, v, pk);
        chk(v == 32'h2, "R8 csw readback", v, 32'h2);
        wr(1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0, ack);
        chk(mem[2] == 32'hDEAD_BEEF, "R10 memory write at tar", mem[2], 32'hDEADBEEF);
        rd(1'b1, 2'd1, ack, v, pk);
        chk(v == 32'h8, "R11 tar holds without increment", v, 32'h8);
        mem[2] = 32'h0BAD_F00D;
        rd(1'b1, 2'd3, ack, v, pk);
        chk(v == 32'h0BAD_F00D && pk, "R10 memory read at tar", v, 32'h0BADF00D);
        wr(1'b1, 2'd3, 32'h7777_7777, 1'b1, ack);
        chk(mem[2] == 32'h0BAD_F00D, "R12 bad data parity discarded", mem[2], 32'h0BADF00D);
    endtask

    task automatic t_autoinc;
        logic [2:0] ack; logic [31:0] v; logic pk;
        wr(1'b1, 2'd0, 32'h0000_0012, 1'b0, ack);
        wr(1'b1, 2'd1, 32'h0000_0010, 1'b0, ack);
        wr(1'b1, 2'd3, 32'h1111_0004, 1'b0, ack);
        wr(1'b1, 2'd3, 32'h2222_0005, 1'b0, ack);
        chk(mem[4] == 32'h1111_0004, "R11 first word", mem[4], 32'h11110004);
        chk(mem[5] == 32'h2222_0005, "R11 second word", mem[5], 32'h22220005);
        rd(1'b1, 2'd1, ack, v, pk);
        chk(v == 32'h18, "R8 R11 tar after two steps", v, 32'h18);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'hA5A5_0000 | i;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_then_id();
        t_id_write();
        t_bad_request();
        t_fault_unpowered();
        t_power();
        t_before_csw();
        t_word_access();
        t_autoinc();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule